// File: doc/BRIEF.md
# Flash Write-Enable and Protection Controller

This block keeps the status byte of a serial flash device and decides whether each modifying command may proceed. A front-end that has already deserialized the command stream hands it one decoded command per beat: an operation code, the target byte address and, for a status write, the new status byte. The block checks the write-enable latch, the protected address region and the hardware lock formed by a register bit together with the active-low write-protect pin. It then answers each command with a grant or a reject.

A granted program, erase or status write sets the busy flag for a fixed number of clock cycles, set by parameters. This stands in for the array timing. When that interval ends, the busy flag drops and the write-enable latch clears on its own. The status byte is a plain output and is valid in every cycle, including while an operation is in progress.

The command input is a valid/ready stream. `cmd_ready` is tied high, so the block never applies back-pressure, and every beat with `cmd_valid` high is taken on that clock edge. Exactly one response beat (`resp_valid` with `resp_grant`) follows on the next cycle. The response has no ready signal, so the front-end must accept it when it appears.

Top module: `flwp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and `resp_valid` is low.
- R2: Every accepted command produces `resp_valid` high for exactly one cycle, in the cycle after it; `cmd_ready` is always high. Op codes are: 0 write-enable, 1 write-disable, 2 status write, 3 page program, 4 sector erase, 5 block erase, 6 chip erase, 7 unused (always rejected, no effect).
- R3: While idle, write-enable is granted and sets the latch (status bit 1); write-disable is granted and clears it.
- R4: A status write, program or erase is rejected when the latch is clear.
- R5: With the latch set, a status write is rejected when status bit 7 (write-lock) is 1 and `wp_n` is 0. Otherwise it is granted, and bits 7, 5 and 4:2 of `cmd_wdata` are copied into the status byte on the grant edge.
- R6: Protect level P = status bits 4:2. A nonzero P protects min(2^(P-1), NBLK) 64 KB blocks, where NBLK = 2^(ADDR_W-16). They are counted from the top of the array when status bit 5 is 0 and from address 0 when it is 1. A program, sector erase or block erase whose address lies in that region is rejected.
- R7: Chip erase is rejected whenever P is nonzero.
- R8: A request that is rejected only by protection (R5, R6, R7) while the latch is set also clears the latch.
- R9: A granted status write, program, sector erase, block erase or chip erase holds the busy flag (status bit 0) for T_WRSR, T_PROG, T_SECT, T_BLK or T_CHIP cycles after the grant edge. When busy drops, the latch is clear.
- R10: While busy, every command is rejected and changes nothing in the status byte.
- R11: Status bit 6 always reads 0, and the status byte is valid in every cycle, busy or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat present |
| cmd_ready | output | 1 | Always 1; command is taken on the edge |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_wdata | input | 8 | New status byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| resp_valid | output | 1 | Response beat, one cycle after a command |
| resp_grant | output | 1 | 1 = command took effect, 0 = rejected |
| status | output | 8 | {lock, 0, bottom, level[2:0], latch, busy} |

## Verification
Directed sequences cover the paths one at a time:
- A program with and without a preceding write-enable separates R4 from a grant.
- Programs aimed at the top block and at block 0, under both region polarities, show whether the protected region sits at the correct end of the array.
- A status write tried with the pin low and then high, while the lock bit is set, isolates the hardware lock.
- Commands sent during an erase show that busy freezes the status byte.

A seeded random stream mixes all op codes, addresses, pin levels and status values, with write-enables inserted at random. A reference model in the bench predicts each response and each status byte, which catches wrong region arithmetic at the intermediate protect levels.

// File: rtl/flwp_pkg.sv
package flwp_pkg;

  typedef enum logic [2:0] {
    OP_WREN  = 3'd0,
    OP_WRDI  = 3'd1,
    OP_WRSR  = 3'd2,
    OP_PROG  = 3'd3,
    OP_SECT  = 3'd4,
    OP_BLK   = 3'd5,
    OP_CHIP  = 3'd6,
    OP_RSVD  = 3'd7
  } flwp_op_e;

  localparam int LVL_W    = 3;
  localparam int ST_BUSY  = 0;
  localparam int ST_LATCH = 1;
  localparam int ST_LVL_L = 2;
  localparam int ST_BOT   = 5;
  localparam int ST_LOCK  = 7;

  function automatic logic is_modify(flwp_op_e op);
    return (op == OP_WRSR) || (op == OP_PROG) || (op == OP_SECT) ||
           (op == OP_BLK)  || (op == OP_CHIP);
  endfunction

endpackage

// File: rtl/flwp_region.sv
module flwp_region #(
  parameter int BLK_W = 5
) (
  input  logic [2:0]       level,
  input  logic             bottom,
  input  logic [BLK_W-1:0] blk,
  output logic             hit
);
  localparam int NBLK = 1 << BLK_W;

  int unsigned span;

  always_comb begin
    if (level == 3'd0) span = 0;
    else if ((32'd1 << (level - 3'd1)) >= NBLK) span = NBLK;
    else span = 32'd1 << (level - 3'd1);
  end

  always_comb begin
    if (span == 0) hit = 1'b0;
    else if (bottom) hit = (32'(blk) < span);
    else hit = (32'(blk) >= (NBLK - span));
  end

  always_comb begin
    a_r6_level0_open: assert (!(level == 3'd0 && hit));
  end

endmodule

// File: rtl/flwp_timer.sv
module flwp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= len;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1));

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !busy);
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/flwp_gate.sv
module flwp_gate
  import flwp_pkg::*;
(
  input  logic     valid,
  input  flwp_op_e op,
  input  logic     busy,
  input  logic     latch,
  input  logic     lock,
  input  logic     wp_n,
  input  logic     level_nz,
  input  logic     hit,
  output logic     grant,
  output logic     set_latch,
  output logic     clr_latch,
  output logic     start,
  output logic     wr_status
);
  logic mod_op, permitted, idle_cmd;

  assign mod_op   = is_modify(op);
  assign idle_cmd = valid && !busy;

  always_comb begin
    unique case (op)
      OP_WRSR: permitted = !(lock && !wp_n);
      OP_PROG, OP_SECT, OP_BLK: permitted = !hit;
      OP_CHIP: permitted = !level_nz;
      default: permitted = 1'b0;
    endcase
  end

  assign grant     = idle_cmd && ((op == OP_WREN) || (op == OP_WRDI) ||
                                  (mod_op && latch && permitted));
  assign set_latch = idle_cmd && (op == OP_WREN);
  assign clr_latch = idle_cmd && ((op == OP_WRDI) ||
                                  (mod_op && latch && !permitted));
  assign start     = grant && mod_op;
  assign wr_status = grant && (op == OP_WRSR);

  always_comb begin
    a_r4_needs_latch: assert (!(start && !latch));
    a_r5_hw_lock: assert (!(wr_status && lock && !wp_n));
  end

endmodule

// File: rtl/flwp_ctrl.sv
module flwp_ctrl
  import flwp_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int BLK_SHIFT = 16,
  parameter int T_WRSR    = 8,
  parameter int T_PROG    = 12,
  parameter int T_SECT    = 24,
  parameter int T_BLK     = 40,
  parameter int T_CHIP    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              wp_n,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic [7:0]        status
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;
  localparam int T_MAX = (T_CHIP > T_BLK ? T_CHIP : T_BLK) > T_SECT ?
                         (T_CHIP > T_BLK ? T_CHIP : T_BLK) : T_SECT;
  localparam int T_TOP = (T_MAX > T_PROG ? T_MAX : T_PROG) > T_WRSR ?
                         (T_MAX > T_PROG ? T_MAX : T_PROG) : T_WRSR;
  localparam int CNT_W = $clog2(T_TOP + 1);

  flwp_op_e         op;
  logic             latch, lock, bottom;
  logic [LVL_W-1:0] level;
  logic             busy, done, hit;
  logic             grant, set_latch, clr_latch, start, wr_status;
  logic [CNT_W-1:0] len;
  logic             addr_low_unused, wdata6_unused;

  assign op              = flwp_op_e'(cmd_op);
  assign cmd_ready       = 1'b1;
  assign addr_low_unused = ^cmd_addr[BLK_SHIFT-1:0];
  assign wdata6_unused   = cmd_wdata[6];

  flwp_region #(.BLK_W(BLK_W)) u_region (
    .level  (level),
    .bottom (bottom),
    .blk    (cmd_addr[ADDR_W-1:BLK_SHIFT]),
    .hit    (hit)
  );

  flwp_gate u_gate (
    .valid     (cmd_valid),
    .op        (op),
    .busy      (busy),
    .latch     (latch),
    .lock      (lock),
    .wp_n      (wp_n),
    .level_nz  (level != '0),
    .hit       (hit),
    .grant     (grant),
    .set_latch (set_latch),
    .clr_latch (clr_latch),
    .start     (start),
    .wr_status (wr_status)
  );

  always_comb begin
    unique case (op)
      OP_WRSR: len = CNT_W'(T_WRSR);
      OP_PROG: len = CNT_W'(T_PROG);
      OP_SECT: len = CNT_W'(T_SECT);
      OP_BLK:  len = CNT_W'(T_BLK);
      OP_CHIP: len = CNT_W'(T_CHIP);
      default: len = '0;
    endcase
  end

  flwp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .len   (len),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch      <= 1'b0;
      lock       <= 1'b0;
      bottom     <= 1'b0;
      level      <= '0;
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
    end else begin
      resp_valid <= cmd_valid;
      resp_grant <= grant;
      if (done) latch <= 1'b0;
      else if (set_latch) latch <= 1'b1;
      else if (clr_latch) latch <= 1'b0;
      if (wr_status) begin
        lock   <= cmd_wdata[ST_LOCK];
        bottom <= cmd_wdata[ST_BOT];
        level  <= cmd_wdata[ST_LVL_L +: LVL_W];
      end
    end
  end

  assign status = {lock, 1'b0, bottom, level, latch, busy};

  a_r2_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> resp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !resp_valid);
  a_r10_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy |=> !resp_grant);
  a_r10_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(status[7:2]) || !status[ST_LATCH]);
  a_r9_latch_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !latch);
  a_r6_region_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && hit && (op == OP_PROG || op == OP_SECT || op == OP_BLK)
    |=> !resp_grant);
  a_r7_chip_guard: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_CHIP && level != '0 |=> !resp_grant);
  a_r11_bit6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !status[6]);

endmodule

// File: tb/test_flwp_ctrl.sv
module test_flwp_ctrl;
  localparam int ADDR_W = 21;
  localparam int NBLK   = 32;
  localparam int T_WRSR = 8, T_PROG = 12, T_SECT = 24, T_BLK = 40, T_CHIP = 64;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic cmd_ready;
  logic [2:0] cmd_op = 0;
  logic [ADDR_W-1:0] cmd_addr = 0;
  logic [7:0] cmd_wdata = 0;
  logic wp_n = 1;
  logic resp_valid, resp_grant;
  logic [7:0] status;

  int checks = 0, fails = 0;
  bit m_latch, m_lock, m_bot, m_busy;
  logic [2:0] m_lvl;
  int pend_len;

  always #4 clk = ~clk;

  flwp_ctrl i_flwp_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .status(status));

  function automatic logic [7:0] exp_status();
    return {m_lock, 1'b0, m_bot, m_lvl, m_latch, m_busy};
  endfunction

  function automatic bit exp_hit(logic [2:0] lvl, bit bot, int blk);
    int span;
    if (lvl == 0) return 0;
    span = 1 << (lvl - 1);
    if (span > NBLK) span = NBLK;
    return bot ? (blk < span) : (blk >= NBLK - span);
  endfunction

  function automatic int op_len(int op);
    case (op)
      2: return T_WRSR; 3: return T_PROG; 4: return T_SECT;
      5: return T_BLK;  6: return T_CHIP; default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic issue(int op, logic [ADDR_W-1:0] addr, logic [7:0] wd, bit wp);
    bit mod, ok, g;
    cmd_op = op[2:0]; cmd_addr = addr; cmd_wdata = wd; wp_n = wp; cmd_valid = 1;
    mod = (op >= 2 && op <= 6);
    case (op)
      2: ok = !(m_lock && !wp);
      3, 4, 5: ok = !exp_hit(m_lvl, m_bot, int'(addr[ADDR_W-1:16]));
      6: ok = (m_lvl == 0);
      default: ok = 0;
    endcase
    g = !m_busy && (op == 0 || op == 1 || (mod && m_latch && ok));
    if (!m_busy) begin
      if (op == 0) m_latch = 1;
      else if (op == 1) m_latch = 0;
      else if (mod && m_latch && !ok) m_latch = 0;
      if (g && op == 2) begin m_lock = wd[7]; m_bot = wd[5]; m_lvl = wd[4:2]; end
      if (g && mod) begin m_busy = 1; pend_len = op_len(op); end
    end
    @(negedge clk);
    cmd_valid = 0;
    check("R2 resp_valid", resp_valid, 1);
    check(mod ? "R4/R5/R6/R7/R10 grant" : "R3/R10 grant", resp_grant, g);
    check("R11 status after command", status, exp_status());
  endtask

  task automatic wait_done(int n);
    repeat (n - 1) @(negedge clk);
    check("R9 busy still set", status[0], 1);
    @(negedge clk);
    m_busy = 0; m_latch = 0;
    check("R9 idle and latch clear", status, exp_status());
  endtask

  task automatic run(int op, logic [ADDR_W-1:0] addr, logic [7:0] wd, bit wp);
    bit was_busy;
    was_busy = m_busy;
    issue(op, addr, wd, wp);
    if (!was_busy && m_busy) wait_done(pend_len);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", status, 8'h00);
    check("R1 reset resp", resp_valid, 0);
    check("R2 ready high", cmd_ready, 1);
    @(negedge clk);
    check("R2 no response when idle", resp_valid, 0);

    run(3, 21'h000100, 0, 1);            // R4: program without latch
    run(0, 0, 0, 1);                     // R3 set latch
    run(1, 0, 0, 1);                     // R3 clear latch
    run(0, 0, 0, 1);
    run(2, 0, 8'h84, 1);                 // R5: lock=1, level=1, top
    run(0, 0, 0, 1);
    run(3, 21'h1F0000, 0, 1);            // R6/R8: top block protected, latch cleared
    check("R8 latch cleared by protect", status[1], 0);
    run(0, 0, 0, 1);
    run(3, 21'h000000, 0, 1);            // R6: block 0 open
    run(0, 0, 0, 1);
    run(6, 0, 0, 1);                     // R7: chip erase with level set
    run(0, 0, 0, 1);
    run(2, 0, 8'hA4, 0);                 // R5: hardware lock
    check("R5 lock kept level", status[4:2], 3'd1);
    run(0, 0, 0, 1);
    run(2, 0, 8'hA8, 1);                 // R5: pin high, bottom, level 2
    run(0, 0, 0, 1);
    run(4, 21'h010000, 0, 1);            // R6: block 1 protected from bottom
    run(0, 0, 0, 1);
    run(5, 21'h1F0000, 0, 1);            // R6: top open in bottom mode
    run(0, 0, 0, 1);
    run(2, 0, 8'h00, 1);
    run(0, 0, 0, 1);
    issue(4, 21'h0A0000, 0, 1);          // R10: commands while busy
    issue(1, 0, 0, 1);
    issue(2, 0, 8'h9C, 1);
    check("R10 latch held while busy", status[1], 1);
    wait_done(T_SECT - 2);
    run(0, 0, 0, 1);
    run(6, 0, 0, 1);                     // R7/R9: chip erase allowed at level 0
    run(7, 0, 0, 1);                     // R2 unused op

    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 9) < 7) run(0, 0, 0, 1);
      run($urandom_range(0, 7), ADDR_W'($urandom), 8'($urandom),
          bit'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule